// File: doc/BRIEF.md
# Return Address Stack with Interrupt Guard

This block keeps the return addresses of a small processor core in a six-level hardware stack. When the core executes a subroutine call, it raises a call strobe together with the program-counter value to save. The block pushes that value, and a later return strobe pops it back out on the return-address output. Interrupt acknowledgment also goes through the block. A request is accepted and pushed only while a level is free. When every level is occupied, the request is remembered, and the acknowledgment is granted as soon as a return frees a level.

Calls are never blocked. A call made on a full stack still pushes. The storage is a ring, so the new address replaces the oldest one, and the most recent six addresses always survive. Both the stored addresses and the pointer are private to the block: the only way to see them is through the return-address output after a return. A return on an empty stack does not move the pointer. It repeats the value of the latest real return and raises a one-cycle underflow flag. A call or acknowledgment in the same cycle as a return is handled as pop then push.

Top module: `ret_addr_stack`

## Requirements
- R1: The stack holds six addresses. After five pushes from empty, `full_o` reads 0; after the sixth, it reads 1. `full_o` changes in the cycle after the push.
- R2: A push saves `pc_i` of the push cycle. Returns give the saved addresses back in last-in, first-out order.
- R3: `ret_addr_o` takes its new value one cycle after `ret_i` is sampled high, and holds its value in every cycle after `ret_i` was low.
- R4: After synchronous reset, `ret_addr_o` is 0, `irq_ack_o` is 0, `full_o` is 0 and `underflow_o` is 0, and the stack is empty.
- R5: An interrupt request on a stack that is not full, with no call in the same cycle, pushes `pc_i` and pulses `irq_ack_o` high for one cycle, the cycle after the request.
- R6: While the stack is full, an interrupt request is latched and `irq_ack_o` stays 0. In the first cycle that `ret_i` is high, the interrupt is taken: the return pops first, `pc_i` of that cycle is pushed, and `irq_ack_o` pulses in the next cycle.
- R7: A call on a full stack pushes and discards the oldest entry. After seven calls from empty, six returns give back calls seven down to two.
- R8: When a call and an interrupt are wanted in the same cycle, the call is pushed and the interrupt stays pending. It is acknowledged in a later cycle that has no call.
- R9: A return on an empty stack pulses `underflow_o` for one cycle and leaves the stack empty. In that case `ret_addr_o` repeats the address given by the most recent successful return.
- R10: A push together with a return on a non-empty stack outputs the top address and replaces it with the new one, so the depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Subroutine call: push `pc_i` |
| irq_req_i | input | 1 | Unmasked interrupt request |
| ret_i | input | 1 | Return: pop top address |
| pc_i | input | ADDR_W | Address to save on a push |
| ret_addr_o | output | ADDR_W | Address delivered by the latest return |
| irq_ack_o | output | 1 | One-cycle interrupt acknowledgment |
| full_o | output | 1 | All six levels occupied |
| underflow_o | output | 1 | Return was made on an empty stack |

## Verification
The bound checker watches several rules on every cycle:
- an acknowledgment that follows a full cycle must coincide with a return, and no acknowledgment follows a cycle that had a call;
- underflow only follows a return and never appears with the full flag;
- `ret_addr_o` is stable after a cycle without a return;
- the full flag survives any cycle without a return.

Other behaviours need the bench's scenarios and its reference queue to show them: last-in, first-out ordering, loss of the oldest entry on overflow, pop-then-push on a combined request, and the value repeated on an empty return.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // request pattern seen by the pointer control: {push, pop}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } stack_op_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             full_o,
  output logic             underflow_o
);
  logic [PTR_W-1:0] top_q, top_d, prev_slot, next_slot;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty, unf_d;
  stack_op_e        op;

  assign empty     = (cnt_q == '0);
  assign prev_slot = (top_q == '0) ? PTR_W'(DEPTH - 1) : top_q - PTR_W'(1);
  assign next_slot = (top_q == PTR_W'(DEPTH - 1)) ? '0 : top_q + PTR_W'(1);
  assign rd_addr_o = empty ? top_q : prev_slot;
  assign op        = stack_op_e'({push_i, pop_i});

  always_comb begin
    top_d     = top_q;
    cnt_d     = cnt_q;
    wr_addr_o = top_q;
    unf_d     = 1'b0;
    unique case (op)
      OP_PUSH: begin
        top_d = next_slot;
        if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + CNT_W'(1);
      end
      OP_POP: begin
        if (empty) unf_d = 1'b1;
        else begin
          top_d = prev_slot;
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      OP_SWAP: begin
        if (empty) begin
          unf_d = 1'b1;
          top_d = next_slot;
          cnt_d = CNT_W'(1);
        end else begin
          wr_addr_o = prev_slot;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q       <= '0;
      cnt_q       <= '0;
      full_o      <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      top_q       <= top_d;
      cnt_q       <= cnt_d;
      full_o      <= (cnt_d == CNT_W'(DEPTH));
      underflow_o <= unf_d;
    end
  end
endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 13,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wa_i,
  input  logic [ADDR_W-1:0] wd_i,
  input  logic              re_i,
  input  logic [PTR_W-1:0]  ra_i,
  output logic [ADDR_W-1:0] rd_o
);
  logic [ADDR_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) slots[wa_i] <= wd_i;
  end

  // read-before-write: a same-cycle pop sees the old top
  always_ff @(posedge clk) begin
    if (rst)       rd_o <= '0;
    else if (re_i) rd_o <= slots[ra_i];
  end
endmodule

// File: rtl/ras_irq_guard.sv
module ras_irq_guard (
  input  logic clk,
  input  logic rst,
  input  logic irq_req_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic full_i,
  output logic take_o,
  output logic ack_o
);
  logic pend_q, want;

  assign want   = pend_q | irq_req_i;
  assign take_o = want & ~call_i & (~full_i | ret_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      pend_q <= want & ~take_o;
      ack_o  <= take_o;
    end
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              irq_req_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              irq_ack_o,
  output logic              full_o,
  output logic              underflow_o
);
  logic             take_irq, push;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  assign push = call_i | take_irq;

  ras_irq_guard u_guard (
    .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .call_i(call_i),
    .ret_i(ret_i), .full_i(full_o), .take_o(take_irq), .ack_o(irq_ack_o)
  );

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_i(push), .pop_i(ret_i),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .full_o(full_o), .underflow_o(underflow_o)
  );

  ras_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst), .we_i(push), .wa_i(wr_addr), .wd_i(pc_i),
    .re_i(ret_i), .ra_i(rd_addr), .rd_o(ret_addr_o)
  );
endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              call_i,
  input logic              irq_req_i,
  input logic              ret_i,
  input logic [ADDR_W-1:0] ret_addr_o,
  input logic              irq_ack_o,
  input logic              full_o,
  input logic              underflow_o
);
  logic unused_in;
  assign unused_in = irq_req_i;

  assert_ack_full_needs_ret_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_o && $past(full_o)) |-> $past(ret_i));

  assert_call_beats_irq_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> !$past(call_i));

  assert_underflow_after_ret_R9: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> ($past(ret_i) && !full_o));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ret_i |=> $stable(ret_addr_o));

  assert_full_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (full_o && !ret_i) |=> full_o);
endmodule

bind ret_addr_stack ras_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  localparam int AW = 13;
  localparam int DEP = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic call_i = 0, irq_req_i = 0, ret_i = 0;
  logic [AW-1:0] pc_i = '0;
  logic [AW-1:0] ret_addr_o;
  logic irq_ack_o, full_o, underflow_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW), .DEPTH(DEP)) i_ret_addr_stack (.*);

  // behavioural reference
  int unsigned stk[$];
  bit pend = 0;
  int unsigned last_pop = 0, e_ret = 0;
  bit e_ack = 0, e_full = 0, e_unf = 0;

  always @(posedge clk) begin
    if (rst) begin
      stk.delete(); pend = 0; e_ret = 0; e_ack = 0; e_full = 0; e_unf = 0;
    end else begin
      bit want, take;
      want = pend | irq_req_i;
      take = want && !call_i && (stk.size() < DEP || ret_i);
      e_unf = 0;
      if (ret_i) begin
        if (stk.size() == 0) begin
          e_unf = 1; e_ret = last_pop;
        end else begin
          e_ret = stk.pop_back(); last_pop = e_ret;
        end
      end
      if (call_i || take) begin
        if (stk.size() == DEP) void'(stk.pop_front());
        stk.push_back(int'(pc_i));
      end
      pend = want && !take;
      e_ack = take;
      e_full = (stk.size() == DEP);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 ret_addr", int'(ret_addr_o), int'(e_ret));
      chk("R6 irq_ack", int'(irq_ack_o), int'(e_ack));
      chk("R1 full", int'(full_o), int'(e_full));
      chk("R9 underflow", int'(underflow_o), int'(e_unf));
    end
  end

  task automatic step(input bit c, input bit q, input bit r, input int pc);
    call_i = c; irq_req_i = q; ret_i = r; pc_i = AW'(pc);
    @(negedge clk);
    call_i = 0; irq_req_i = 0; ret_i = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R4 reset state
    chk("R4 ret_addr", int'(ret_addr_o), 0);
    chk("R4 ack", int'(irq_ack_o), 0);
    chk("R4 full", int'(full_o), 0);
    chk("R4 underflow", int'(underflow_o), 0);
    // R1 depth
    for (int i = 0; i < 5; i++) step(1, 0, 0, 100 + i);
    chk("R1 five not full", int'(full_o), 0);
    step(1, 0, 0, 105);
    chk("R1 six full", int'(full_o), 1);
    // R6 withheld interrupt
    step(0, 1, 0, 150);
    chk("R6 withheld", int'(irq_ack_o), 0);
    step(0, 0, 0, 151);
    chk("R6 still withheld", int'(irq_ack_o), 0);
    step(0, 0, 1, 200);
    chk("R6 ack on ret", int'(irq_ack_o), 1);
    chk("R2 top popped", int'(ret_addr_o), 105);
    chk("R6 depth kept", int'(full_o), 1);
    // R2 LIFO drain; R5 pushed value came first
    step(0, 0, 1, 0);
    chk("R5 irq pc saved", int'(ret_addr_o), 200);
    for (int i = 4; i >= 0; i--) begin
      step(0, 0, 1, 0);
      chk("R2 lifo", int'(ret_addr_o), 100 + i);
    end
    // R9 empty return
    step(0, 0, 1, 0);
    chk("R9 underflow pulse", int'(underflow_o), 1);
    chk("R9 repeats last", int'(ret_addr_o), 100);
    step(0, 0, 0, 0);
    chk("R9 pulse ends", int'(underflow_o), 0);
    // R7 overflow drops oldest
    for (int i = 0; i < 7; i++) step(1, 0, 0, 300 + i);
    for (int i = 6; i >= 1; i--) begin
      step(0, 0, 1, 0);
      chk("R7 newest six", int'(ret_addr_o), 300 + i);
    end
    step(0, 0, 1, 0);
    chk("R7 oldest lost", int'(underflow_o), 1);
    // R8 call beats interrupt
    step(1, 1, 0, 400);
    chk("R8 no ack with call", int'(irq_ack_o), 0);
    step(0, 0, 0, 401);
    chk("R8 ack later", int'(irq_ack_o), 1);
    step(0, 0, 1, 0);
    chk("R8 irq on top", int'(ret_addr_o), 401);
    step(0, 0, 1, 0);
    chk("R8 call below", int'(ret_addr_o), 400);
    // R10 push with pop
    step(1, 0, 0, 500);
    step(1, 0, 1, 501);
    chk("R10 old top out", int'(ret_addr_o), 500);
    step(0, 0, 1, 0);
    chk("R10 new top", int'(ret_addr_o), 501);
    chk("R10 no underflow", int'(underflow_o), 0);
    step(0, 0, 1, 0);
    chk("R10 depth one", int'(underflow_o), 1);
    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3] & r[4], r[5] & ~r[6], int'(r[20:8]));
    end
    done = 1;
    summary();
  end
endmodule